// File: doc/BRIEF.md
# Shared-Counter Event Timer Block

The block keeps one 64-bit up-counter that advances by one on each clock while a global run bit is set. A parameterised set of timer channels, at most 32, watches that counter. Each channel holds a 64-bit match value and compares it for equality with the counter. A channel fires once and disarms when it runs one-shot. When it runs periodic, it fires and then moves its match value forward by a programmed period. Every firing sets a sticky status bit for the channel. Each channel has its own level interrupt line, which is the status bit gated by the channel's interrupt enable.

Software reaches the block through a plain 32-bit register port with single-cycle read and write strobes and a word address. Read data appears one cycle after the read strobe. When the low half of the counter is read, the high half is captured at the same moment, so a following read of the high half gives a value that matches the low half. The counter can be loaded only while it is stopped.

Word map: 0 = control (bit 0 run), 1 = counter low, 2 = counter high, 3 = status (bit i for channel i, write 1 to clear). Channel i sits at word 16 + 8·i, with these offsets: +0 config (bit 0 interrupt enable, bit 1 periodic), +1 match low, +2 match high, +3 period low, +4 period high. All other addresses read as zero.

Top module: `evtmr_block`

## Requirements
- R1: While control bit 0 is 1, the counter rises by exactly one per clock. While it is 0, the counter holds its value.
- R2: Writes to counter low (word 1) and counter high (word 2) load that half only while the counter is stopped. While the counter runs, such writes have no effect.
- R3: A read of word 1 returns the low 32 bits and captures the high 32 bits of the same count. A read of word 2 returns that captured half, even if the counter has carried into its high half since then.
- R4: A one-shot channel sets its status bit in the cycle in which the counter equals its match value. Once the counter has passed that value, the channel does not fire again.
- R5: Status bits stay set until software writes 1 to the bit in word 3. Writing 0 leaves a bit unchanged.
- R6: Interrupt line i is high exactly when status bit i and config bit 0 of channel i are both 1.
- R7: A periodic channel adds its period to its match value on every firing, so it fires at a fixed rate. Config reads back bit 1 as set.
- R8: On a channel that is not periodic-capable (parameter `PER_CAP` bit i is 0, default channels 1 and 3), config bit 1 reads 0. The channel behaves as one-shot and its match value is never advanced.
- R9: While the counter is stopped, no channel fires, even when the counter equals its match value.
- R10: A write to either half of a channel's match value re-arms it, so a later equality fires again.
- R11: Channels fire independently. A match on one channel sets no other channel's status.
- R12: After reset the counter, control, status, configuration and interrupt lines are all zero, and no channel is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | NUM_TMR | Per-channel level interrupt |

## Verification
The hardest state to reach is a read of the counter's high half after the low half has wrapped between the two reads. No 64-bit counter reaches a carry in a short run. The stimulus therefore stops the counter, loads it a few counts below a low-half wrap, restarts it, reads the low half, and waits until the carry has happened before it reads the high half. For periodic reload, the bench reads back the final count. From that count it works out how many match points were crossed, and it predicts the advanced match value from that number.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;
  localparam int REG_W  = 32;
  localparam int CNT_W  = 64;
  localparam int ADDR_W = 10;
  localparam int MAX_TMR = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = 10'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 10'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 10'd2;
  localparam logic [ADDR_W-1:0] A_STAT   = 10'd3;
  localparam logic [ADDR_W-1:0] A_TBASE  = 10'd16;

  localparam logic [2:0] O_CFG  = 3'd0;
  localparam logic [2:0] O_M_LO = 3'd1;
  localparam logic [2:0] O_M_HI = 3'd2;
  localparam logic [2:0] O_P_LO = 3'd3;
  localparam logic [2:0] O_P_HI = 3'd4;
endpackage

// File: rtl/evtmr_counter.sv
module evtmr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ld_lo_i,
  input  logic             ld_hi_i,
  input  logic [CNT_W/2-1:0] ld_data_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W/2-1:0] hi_snap_o
);
  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [HALF-1:0]  hi_q, hi_n;

  always_comb begin
    cnt_n = cnt_q;
    if (run_i) begin
      cnt_n = cnt_q + 1'b1;
    end else begin
      if (ld_lo_i) cnt_n[HALF-1:0]     = ld_data_i;
      if (ld_hi_i) cnt_n[CNT_W-1:HALF] = ld_data_i;
    end
    hi_n = snap_i ? cnt_q[CNT_W-1:HALF] : hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      hi_q  <= hi_n;
    end
  end

  assign cnt_o     = cnt_q;
  assign hi_snap_o = hi_q;

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !ld_lo_i && !ld_hi_i) |=> $stable(cnt_q));
  assert_hi_snap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> hi_q == $past(cnt_q[CNT_W-1:HALF]));
endmodule

// File: rtl/evtmr_channel.sv
module evtmr_channel #(
  parameter int CNT_W  = 64,
  parameter int REG_W  = 32,
  parameter bit PER_OK = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             cfg_we_i,
  input  logic             m_lo_we_i,
  input  logic             m_hi_we_i,
  input  logic             p_lo_we_i,
  input  logic             p_hi_we_i,
  input  logic             clr_i,
  output logic             ien_o,
  output logic             per_o,
  output logic             stat_o,
  output logic [CNT_W-1:0] match_o,
  output logic [CNT_W-1:0] period_o
);
  localparam int HALF = CNT_W / 2;

  logic             ien_q, ien_n, per_q, per_n;
  logic             armed_q, armed_n, stat_q, stat_n;
  logic [CNT_W-1:0] match_q, match_n, period_q, period_n;
  logic             hit, m_we;

  assign m_we = m_lo_we_i | m_hi_we_i;
  assign hit  = run_i & armed_q & (cnt_i == match_q);

  always_comb begin
    ien_n    = ien_q;
    per_n    = per_q;
    match_n  = match_q;
    period_n = period_q;
    armed_n  = armed_q;
    if (cfg_we_i) begin
      ien_n = wdata_i[0];
      per_n = wdata_i[1] & PER_OK;
    end
    if (p_lo_we_i) period_n[HALF-1:0]     = wdata_i[HALF-1:0];
    if (p_hi_we_i) period_n[CNT_W-1:HALF] = wdata_i[HALF-1:0];
    if (m_we) begin
      if (m_lo_we_i) match_n[HALF-1:0]     = wdata_i[HALF-1:0];
      if (m_hi_we_i) match_n[CNT_W-1:HALF] = wdata_i[HALF-1:0];
      armed_n = 1'b1;
    end else if (hit) begin
      if (per_q) match_n = match_q + period_q;
      else       armed_n = 1'b0;
    end
    stat_n = hit | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= 1'b0;
      per_q    <= 1'b0;
      armed_q  <= 1'b0;
      stat_q   <= 1'b0;
      match_q  <= '0;
      period_q <= '0;
    end else begin
      ien_q    <= ien_n;
      per_q    <= per_n;
      armed_q  <= armed_n;
      stat_q   <= stat_n;
      match_q  <= match_n;
      period_q <= period_n;
    end
  end

  assign ien_o    = ien_q;
  assign per_o    = per_q;
  assign stat_o   = stat_q;
  assign match_o  = match_q;
  assign period_o = period_q;

  assert_oneshot_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !per_q && !m_we) |=> !armed_q);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_q) |-> $past(clr_i));
  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per_q && !m_we) |=> match_q == $past(match_q) + $past(period_q));
  assert_quiet_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !$rose(stat_q));
  assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    m_we |=> armed_q);
endmodule

// File: rtl/evtmr_block.sv
module evtmr_block
  import evtmr_pkg::*;
#(
  parameter int          NUM_TMR = 4,
  parameter logic [31:0] PER_CAP = 32'h0000_0005
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]   bus_wdata,
  output logic [REG_W-1:0]   bus_rdata,
  output logic [NUM_TMR-1:0] irq
);
  localparam int HALF = CNT_W / 2;

  logic               run_q, run_n;
  logic [REG_W-1:0]   rdata_q, rdata_n;
  logic [CNT_W-1:0]   cnt;
  logic [HALF-1:0]    hi_snap;
  logic [ADDR_W-1:0]  rel;
  logic               in_tregion;
  logic [2:0]         off;
  logic [NUM_TMR-1:0] tsel, ien_w, per_w, stat_w, clr_w;
  logic [CNT_W-1:0]   match_w  [NUM_TMR];
  logic [CNT_W-1:0]   period_w [NUM_TMR];

  assign rel        = bus_addr - A_TBASE;
  assign in_tregion = (bus_addr >= A_TBASE) && (rel[ADDR_W-1:8] == '0);
  assign off        = rel[2:0];
  assign clr_w      = (bus_wr && bus_addr == A_STAT) ? bus_wdata[NUM_TMR-1:0] : '0;

  evtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_q),
    .ld_lo_i   (bus_wr && bus_addr == A_CNT_LO),
    .ld_hi_i   (bus_wr && bus_addr == A_CNT_HI),
    .ld_data_i (bus_wdata),
    .snap_i    (bus_rd && bus_addr == A_CNT_LO),
    .cnt_o     (cnt),
    .hi_snap_o (hi_snap)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    assign tsel[i] = in_tregion && (rel[7:3] == 5'(i));
    evtmr_channel #(.CNT_W(CNT_W), .REG_W(REG_W), .PER_OK(PER_CAP[i])) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_q),
      .cnt_i     (cnt),
      .wdata_i   (bus_wdata),
      .cfg_we_i  (bus_wr && tsel[i] && off == O_CFG),
      .m_lo_we_i (bus_wr && tsel[i] && off == O_M_LO),
      .m_hi_we_i (bus_wr && tsel[i] && off == O_M_HI),
      .p_lo_we_i (bus_wr && tsel[i] && off == O_P_LO),
      .p_hi_we_i (bus_wr && tsel[i] && off == O_P_HI),
      .clr_i     (clr_w[i]),
      .ien_o     (ien_w[i]),
      .per_o     (per_w[i]),
      .stat_o    (stat_w[i]),
      .match_o   (match_w[i]),
      .period_o  (period_w[i])
    );
  end

  always_comb begin
    run_n = (bus_wr && bus_addr == A_CTRL) ? bus_wdata[0] : run_q;
    rdata_n = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:   rdata_n = {{(REG_W-1){1'b0}}, run_q};
        A_CNT_LO: rdata_n = cnt[HALF-1:0];
        A_CNT_HI: rdata_n = hi_snap;
        A_STAT:   rdata_n[NUM_TMR-1:0] = stat_w;
        default: begin
          for (int i = 0; i < NUM_TMR; i++) begin
            if (tsel[i]) begin
              case (off)
                O_CFG:   rdata_n = {{(REG_W-2){1'b0}}, per_w[i], ien_w[i]};
                O_M_LO:  rdata_n = match_w[i][HALF-1:0];
                O_M_HI:  rdata_n = match_w[i][CNT_W-1:HALF];
                O_P_LO:  rdata_n = period_w[i][HALF-1:0];
                O_P_HI:  rdata_n = period_w[i][CNT_W-1:HALF];
                default: rdata_n = '0;
              endcase
            end
          end
        end
      endcase
    end else begin
      rdata_n = rdata_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      run_q   <= run_n;
      rdata_q <= rdata_n;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = stat_w & ien_w;

  assert_onehot_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tsel));
  assert_irq_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && bus_wdata[NUM_TMR-1:0] == stat_w && run_q == 1'b0) |=> irq == '0);
endmodule

// File: tb/evtmr_block_tb.sv
`timescale 1ns/1ps
module evtmr_block_tb;
  import evtmr_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  evtmr_block u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [9:0]  a;
    logic [31:0] d;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 10'd0,  32'h0,    4'd12}, // R12 control
    '{1'b0, 10'd3,  32'h0,    4'd12}, // R12 status
    '{1'b0, 10'd1,  32'h0,    4'd12}, // R12 count low
    '{1'b0, 10'd2,  32'h0,    4'd12}, // R12 count high
    '{1'b1, 10'd24, 32'h3,    4'd8},
    '{1'b0, 10'd24, 32'h1,    4'd8},  // R8 periodic bit dropped
    '{1'b1, 10'd16, 32'h3,    4'd7},
    '{1'b0, 10'd16, 32'h3,    4'd7},  // R7 periodic bit kept
    '{1'b1, 10'd33, 32'h1234, 4'd10},
    '{1'b0, 10'd33, 32'h1234, 4'd10}, // R10 match readback
    '{1'b1, 10'd44, 32'hA5,   4'd7},
    '{1'b0, 10'd44, 32'hA5,   4'd7}   // R7 period readback
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_cnt(output logic [63:0] c);
    logic [31:0] lo, hi;
    rd(10'd1, lo);
    rd(10'd2, hi);
    c = {hi, lo};
  endtask

  task automatic run_for(input int n);
    wr(10'd0, 32'h1);
    repeat (n) @(negedge clk);
    wr(10'd0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, w0, w1;
    logic [63:0] c, f, expm;
    int n;
    repeat (3) @(negedge clk);
    chk("R12 irq in reset", {60'b0, irq}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 irq after reset", {60'b0, irq}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k].wr) wr(VEC[k].a, VEC[k].d);
      else begin
        rd(VEC[k].a, r);
        chk($sformatf("R%0d table entry %0d", VEC[k].rq, k), {32'b0, r}, {32'b0, VEC[k].d});
      end
    end

    // R2 load while stopped, R1 hold while stopped
    wr(10'd1, 32'd100); wr(10'd2, 32'd0);
    rd_cnt(c); chk("R2 load stopped", c, 64'd100);
    repeat (5) @(negedge clk);
    rd_cnt(c); chk("R1 hold stopped", c, 64'd100);

    // R9: equality while stopped does not fire
    wr(10'd16, 32'h1); wr(10'd18, 32'h0); wr(10'd17, 32'd100);
    wr(10'd24, 32'h0); wr(10'd26, 32'h0); wr(10'd25, 32'd104);
    wr(10'd32, 32'h1); wr(10'd34, 32'h0); wr(10'd33, 32'd5000);
    repeat (8) @(negedge clk);
    rd(10'd3, r); chk("R9 no fire stopped", {32'b0, r}, 64'h0);
    chk("R9 no irq stopped", {60'b0, irq}, 64'h0);

    // R4 / R11 / R6
    run_for(20);
    rd_cnt(f);
    chk("R1 advanced", {63'b0, (f > 64'd110)}, 64'd1);
    rd(10'd3, r); chk("R4 R11 status", {32'b0, r}, 64'h3);
    chk("R6 irq gated", {60'b0, irq}, 64'h1);
    wr(10'd24, 32'h1);
    @(negedge clk);
    chk("R6 irq enabled", {60'b0, irq}, 64'h3);

    // R5 sticky and write-one-to-clear
    wr(10'd3, 32'h0); rd(10'd3, r); chk("R5 write zero", {32'b0, r}, 64'h3);
    wr(10'd3, 32'h1); rd(10'd3, r); chk("R5 clear bit0", {32'b0, r}, 64'h2);
    wr(10'd3, 32'h2); rd(10'd3, r); chk("R5 clear bit1", {32'b0, r}, 64'h0);
    chk("R6 irq cleared", {60'b0, irq}, 64'h0);

    // R4: no refire after the match point has passed
    run_for(20);
    rd(10'd3, r); chk("R4 no refire", {32'b0, r}, 64'h0);

    // R10: rewriting match re-arms a one-shot channel
    rd_cnt(c);
    wr(10'd17, c[31:0] + 32'd3);
    run_for(15);
    rd(10'd3, r); chk("R10 rearm fires", {32'b0, r}, 64'h1);
    wr(10'd3, 32'hF);

    // R7 periodic reload and R8 non-capable channel
    rd_cnt(c);
    wr(10'd16, 32'h3); wr(10'd19, 32'd10); wr(10'd20, 32'h0);
    wr(10'd17, c[31:0] + 32'd5);
    wr(10'd24, 32'h3); wr(10'd27, 32'd10);
    wr(10'd25, c[31:0] + 32'd6);
    run_for(40);
    rd_cnt(f);
    n = 0;
    for (logic [63:0] m = c + 64'd5; m <= f - 64'd1; m += 64'd10) n++;
    expm = c + 64'd5 + 64'd10 * 64'(n);
    rd(10'd17, r); chk("R7 reload match", {32'b0, r}, {32'b0, expm[31:0]});
    chk("R7 several firings", {63'b0, (n >= 3)}, 64'd1);
    rd(10'd25, r); chk("R8 no reload", {32'b0, r}, {32'b0, c[31:0] + 32'd6});
    rd(10'd3, r); chk("R8 R7 status", {32'b0, r}, 64'h3);
    wr(10'd3, 32'hF);

    // R3 consistent high half across a low-half carry
    wr(10'd1, 32'hFFFF_FFF0); wr(10'd2, 32'h0);
    wr(10'd0, 32'h1);
    rd(10'd1, w0);
    chk("R3 low near wrap", {63'b0, (w0 >= 32'hFFFF_FFF0)}, 64'd1);
    repeat (40) @(negedge clk);
    rd(10'd2, r); chk("R3 latched high", {32'b0, r}, 64'h0);
    rd(10'd1, w0);
    rd(10'd2, r); chk("R3 high after carry", {32'b0, r}, 64'h1);
    // R2 load ignored while running
    wr(10'd1, 32'd7);
    wr(10'd0, 32'h0);
    rd(10'd1, w1);
    chk("R2 ignored running", {63'b0, (w1 > w0)}, 64'd1);
    rd(10'd2, r); chk("R2 high kept", {32'b0, r}, 64'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule